// File: doc/BRIEF.md
# RTC interrupt emulation engine

This block stands in for the interrupt logic of a battery-backed real-time clock. A 32-bit free-running counter is compared against a comparator that the block owns. Each time the counter reaches or passes the comparator, the block takes one base tick. The base tick rate is 64 Hz, and the default step is the counter frequency divided by 64. On every tick the block raises up to three flags:

- an update flag, when the seconds value changes;
- an alarm flag, when hour, minute and second all match the programmed alarm;
- a periodic flag, at a rate that software selects as a power of two.

After a tick, the block moves the comparator forward by whole steps until it is ahead of the counter again. It reports how many steps were missed. When periodic mode is on, those missed ticks also count toward the periodic divider.

The periodic rate is given as a base-two exponent: a value k selects 2^k Hz, and the legal range of k is 1 to 13. At rates of 64 Hz or less, the comparator keeps the base step and a divider raises the periodic flag once every 64/2^k ticks. Above 64 Hz, the step shrinks to the counter frequency divided by the rate, and the flag is raised on every tick. The current time of day arrives on input pins; reading the calendar clock is not part of this block.

Top module: `rtc_irq_emu`

## Requirements
- R1: After reset, irq_strobe is 0, irq_word is 0, cmp_next is 0 and lost_ticks is 0.
- R2: When any enable bit goes from 0 to 1, cmp_next becomes cnt_now plus the step one clock later. The step is CNT_FREQ>>6 unless periodic mode runs above 64 Hz.
- R3: A tick occurs when the signed 32-bit value cnt_now - cmp_next is zero or positive. The step is then added to the comparator again and again until cnt_now - cmp_next is negative. Counter wrap is handled by this signed test.
- R4: After a tick, lost_ticks reports the number of additions beyond the first.
- R5: On a tick with update enabled, a seconds value that differs from the recorded one is recorded. It raises the update flag only when the recorded value was valid. A 0-to-1 change of update enable marks the recorded value invalid.
- R6: On a tick with alarm enabled, the alarm flag is raised only when the hour, minute and second inputs all equal the alarm inputs.
- R7: With periodic mode at k<=6, the periodic flag is raised on every 2^(6-k)-th tick, and the divider count returns to zero when the flag is raised.
- R8: With periodic mode enabled, the lost ticks of a tick are added to the divider count before that tick's own increment.
- R9: With periodic mode at k>6, the step is CNT_FREQ>>k and the periodic flag is raised on every tick.
- R10: A tick with at least one flag pulses irq_strobe for one cycle and loads irq_word as follows: bit 4 is update, bit 5 is alarm, bit 6 is periodic, bit 7 is set whenever any flag is set, and bits 15:8 hold 1. A tick with no flag gives no strobe.
- R11: While all three enable bits are 0, no tick occurs and cmp_next holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_now | input | 32 | Free-running counter value |
| cur_hh | input | 5 | Current hour |
| cur_mm | input | 6 | Current minute |
| cur_ss | input | 6 | Current second |
| upd_en | input | 1 | Update interrupt enable |
| alm_en | input | 1 | Alarm interrupt enable |
| per_en | input | 1 | Periodic interrupt enable |
| alm_hh | input | 5 | Alarm hour |
| alm_mm | input | 6 | Alarm minute |
| alm_ss | input | 6 | Alarm second |
| per_rate_log2 | input | RATE_W | Periodic rate exponent k, rate = 2^k Hz |
| irq_strobe | output | 1 | One-cycle pulse when a flag word is produced |
| irq_word | output | 16 | Flag word of the last flagged tick |
| cmp_next | output | 32 | Comparator value of the next tick |
| lost_ticks | output | LOST_W | Missed ticks in the last tick |

## Verification
Ticks are applied in three ways:

- with the counter placed exactly on the comparator;
- with the counter several steps past the comparator, which separates a single addition from a catch-up and shows the lost count feeding the divider;
- across the 32-bit wrap, which shows that the signed test is used rather than an unsigned compare.

The periodic divider is swept over every rate from 2 Hz to 64 Hz, and the fast rates check the shorter step. Alarm patterns with exactly one field mismatched show that all three fields are compared. Update patterns with equal seconds, changed seconds and a fresh enable separate the stored-second rule from a plain edge detector.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;

    localparam int CNT_W      = 32;
    localparam int BASE_SHIFT = 6;     // base tick = 2^6 Hz

    localparam int FLG_UF   = 4;
    localparam int FLG_AF   = 5;
    localparam int FLG_PF   = 6;
    localparam int FLG_IRQF = 7;

    typedef struct packed {
        logic [4:0] hh;
        logic [5:0] mm;
        logic [5:0] ss;
    } hms_t;

    typedef struct packed {
        logic upd;
        logic alm;
        logic per;
    } en_t;

    typedef enum logic {ST_IDLE, ST_CATCH} cmp_st_e;

    // comparator is ahead of the counter when (cnt - cmp) is negative
    function automatic logic cmp_ahead(input logic [CNT_W-1:0] cmp,
                                       input logic [CNT_W-1:0] cnt);
        logic [CNT_W-1:0] diff;
        diff = cnt - cmp;
        return diff[CNT_W-1];
    endfunction

    function automatic logic [15:0] pack_word(input logic uf,
                                              input logic af,
                                              input logic pf);
        logic [15:0] w;
        w           = 16'h0100;
        w[FLG_UF]   = uf;
        w[FLG_AF]   = af;
        w[FLG_PF]   = pf;
        w[FLG_IRQF] = uf | af | pf;
        return w;
    endfunction

endpackage

// File: rtl/rtc_emu_rate.sv
module rtc_emu_rate
    import rtc_emu_pkg::*;
#(
    parameter int CNT_FREQ = 65536,
    parameter int RATE_W   = 4,
    parameter int PIE_W    = 8
) (
    input  logic              per_en,
    input  logic [RATE_W-1:0] rate_log2,
    output logic [CNT_W-1:0]  delta,
    output logic [PIE_W-1:0]  limit
);

    localparam logic [CNT_W-1:0]  FREQ_V     = CNT_W'(CNT_FREQ);
    localparam logic [CNT_W-1:0]  BASE_DELTA = FREQ_V >> BASE_SHIFT;
    localparam logic [RATE_W-1:0] BASE_CODE  = RATE_W'(BASE_SHIFT);

    logic              fast;
    logic [RATE_W-1:0] div_sh;

    always_comb begin
        fast   = per_en && (rate_log2 > BASE_CODE);
        div_sh = BASE_CODE - rate_log2;
        delta  = fast ? (FREQ_V >> rate_log2) : BASE_DELTA;
        limit  = (fast || !per_en) ? PIE_W'(1) : (PIE_W'(1) << div_sh);
    end

endmodule

// File: rtl/rtc_emu_cmp.sv
module rtc_emu_cmp
    import rtc_emu_pkg::*;
#(
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_now,
    input  logic [CNT_W-1:0]  delta,
    input  logic              any_en,
    input  logic              arm_req,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              done_q,
    output logic [LOST_W-1:0] lost_q
);

    cmp_st_e          st_q;
    logic             armed_q;
    logic             passed;
    logic [CNT_W-1:0] cmp_sum;

    always_comb begin
        passed  = !cmp_ahead(cmp_q, cnt_now);
        cmp_sum = cmp_q + delta;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            armed_q <= 1'b0;
            cmp_q   <= '0;
            done_q  <= 1'b0;
            lost_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!any_en) begin
                armed_q <= 1'b0;
                st_q    <= ST_IDLE;
            end else if (arm_req) begin
                armed_q <= 1'b1;
                cmp_q   <= cnt_now + delta;
                st_q    <= ST_IDLE;
            end else begin
                case (st_q)
                    ST_IDLE: begin
                        if (armed_q && passed) begin
                            cmp_q  <= cmp_sum;
                            lost_q <= '0;
                            st_q   <= ST_CATCH;
                        end
                    end
                    ST_CATCH: begin
                        if (passed) begin
                            cmp_q <= cmp_sum;
                            if (lost_q != '1)
                                lost_q <= lost_q + 1'b1;
                        end else begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/rtc_emu_flags.sv
module rtc_emu_flags
    import rtc_emu_pkg::*;
#(
    parameter int PIE_W  = 8,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [LOST_W-1:0] lost,
    input  en_t               en,
    input  logic              upd_rise,
    input  hms_t              cur,
    input  hms_t              alm,
    input  logic [PIE_W-1:0]  limit,
    output logic              strobe_q,
    output logic [15:0]       word_q
);

    logic [5:0]       prev_ss_q;
    logic             prev_ok_q;
    logic [PIE_W-1:0] pie_q;

    logic             sec_new;
    logic             uf_c, af_c, pf_c;
    logic [PIE_W:0]   pie_sum;

    always_comb begin
        sec_new = !prev_ok_q || (cur.ss != prev_ss_q);
        uf_c    = en.upd && sec_new && prev_ok_q;
        af_c    = en.alm && (cur == alm);
        pie_sum = {1'b0, pie_q} + (PIE_W+1)'(lost) + 1'b1;
        pf_c    = en.per && (pie_sum >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ss_q <= '0;
            prev_ok_q <= 1'b0;
            pie_q     <= '0;
            strobe_q  <= 1'b0;
            word_q    <= '0;
        end else begin
            strobe_q <= 1'b0;
            if (done) begin
                if (en.upd && sec_new) begin
                    prev_ss_q <= cur.ss;
                    prev_ok_q <= 1'b1;
                end
                if (en.per)
                    pie_q <= pf_c ? '0 : pie_sum[PIE_W-1:0];
                if (uf_c || af_c || pf_c) begin
                    strobe_q <= 1'b1;
                    word_q   <= pack_word(uf_c, af_c, pf_c);
                end
            end
            if (upd_rise)
                prev_ok_q <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_irq_emu.sv
module rtc_irq_emu
    import rtc_emu_pkg::*;
#(
    parameter int CNT_FREQ = 65536,
    parameter int RATE_W   = 4,
    parameter int PIE_W    = 8,
    parameter int LOST_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       cnt_now,
    input  logic [4:0]        cur_hh,
    input  logic [5:0]        cur_mm,
    input  logic [5:0]        cur_ss,
    input  logic              upd_en,
    input  logic              alm_en,
    input  logic              per_en,
    input  logic [4:0]        alm_hh,
    input  logic [5:0]        alm_mm,
    input  logic [5:0]        alm_ss,
    input  logic [RATE_W-1:0] per_rate_log2,
    output logic              irq_strobe,
    output logic [15:0]       irq_word,
    output logic [31:0]       cmp_next,
    output logic [LOST_W-1:0] lost_ticks
);

    en_t              en_now, en_q;
    hms_t             cur_t, alm_t;
    logic             arm_req, any_en, upd_rise;
    logic [CNT_W-1:0] delta;
    logic [PIE_W-1:0] limit;
    logic             tick_done;

    always_comb begin
        en_now   = '{upd: upd_en, alm: alm_en, per: per_en};
        cur_t    = '{hh: cur_hh, mm: cur_mm, ss: cur_ss};
        alm_t    = '{hh: alm_hh, mm: alm_mm, ss: alm_ss};
        any_en   = |en_now;
        arm_req  = |(en_now & ~en_q);
        upd_rise = en_now.upd & ~en_q.upd;
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_now;
    end

    rtc_emu_rate #(.CNT_FREQ(CNT_FREQ), .RATE_W(RATE_W), .PIE_W(PIE_W)) u_rate (
        .per_en    (per_en),
        .rate_log2 (per_rate_log2),
        .delta     (delta),
        .limit     (limit)
    );

    rtc_emu_cmp #(.LOST_W(LOST_W)) u_cmp (
        .clk     (clk),
        .rst     (rst),
        .cnt_now (cnt_now),
        .delta   (delta),
        .any_en  (any_en),
        .arm_req (arm_req),
        .cmp_q   (cmp_next),
        .done_q  (tick_done),
        .lost_q  (lost_ticks)
    );

    rtc_emu_flags #(.PIE_W(PIE_W), .LOST_W(LOST_W)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .done     (tick_done),
        .lost     (lost_ticks),
        .en       (en_now),
        .upd_rise (upd_rise),
        .cur      (cur_t),
        .alm      (alm_t),
        .limit    (limit),
        .strobe_q (irq_strobe),
        .word_q   (irq_word)
    );

endmodule

// File: rtl/rtc_irq_emu_chk.sv
module rtc_irq_emu_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] cnt_now,
    input logic        upd_en,
    input logic        alm_en,
    input logic        per_en,
    input logic        arm_req,
    input logic [31:0] delta,
    input logic        tick_done,
    input logic [31:0] cmp_next,
    input logic        irq_strobe,
    input logic [15:0] irq_word
);

    // R2: arming loads counter plus step
    p_arm_load_r2: assert property (@(posedge clk) disable iff (rst)
        arm_req |=> (cmp_next == $past(cnt_now) + $past(delta)));

    // R3: a finished catch-up leaves the comparator ahead of the counter it saw
    p_cmp_ahead_r3: assert property (@(posedge clk) disable iff (rst)
        tick_done |-> (($past(cnt_now) - cmp_next) >> 31) == 32'd1);

    // R10: flag word framing
    p_word_form_r10: assert property (@(posedge clk) disable iff (rst)
        irq_strobe |-> (irq_word[15:8] == 8'd1 && irq_word[7] && (irq_word[6:4] != 3'b000)));

    // R10: strobe is a single-cycle pulse
    p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        irq_strobe |=> !irq_strobe);

    // R11: with every enable clear the comparator does not move
    p_hold_off_r11: assert property (@(posedge clk) disable iff (rst)
        (!upd_en && !alm_en && !per_en) |=> $stable(cmp_next));

endmodule

bind rtc_irq_emu rtc_irq_emu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_now    (cnt_now),
    .upd_en     (upd_en),
    .alm_en     (alm_en),
    .per_en     (per_en),
    .arm_req    (arm_req),
    .delta      (delta),
    .tick_done  (tick_done),
    .cmp_next   (cmp_next),
    .irq_strobe (irq_strobe),
    .irq_word   (irq_word)
);

// File: tb/rtc_irq_emu_tb_top.sv
`timescale 1ns/1ps
module rtc_irq_emu_tb_top;

    localparam int FREQ = 65536;
    localparam logic [31:0] BASE_D = 32'(FREQ >> 6);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cnt_now = '0;
    logic [4:0]  cur_hh = '0, alm_hh = '0;
    logic [5:0]  cur_mm = '0, cur_ss = '0, alm_mm = '0, alm_ss = '0;
    logic        upd_en = 1'b0, alm_en = 1'b0, per_en = 1'b0;
    logic [3:0]  per_rate_log2 = 4'd6;
    logic        irq_strobe;
    logic [15:0] irq_word;
    logic [31:0] cmp_next;
    logic [7:0]  lost_ticks;

    int n_chk = 0, n_err = 0, n_stb = 0;
    logic [15:0] last_word = '0;
    logic [31:0] ecmp;
    bit finished = 0;

    always #4 clk = ~clk;

    rtc_irq_emu #(.CNT_FREQ(FREQ)) dut_i (
        .clk(clk), .rst(rst), .cnt_now(cnt_now),
        .cur_hh(cur_hh), .cur_mm(cur_mm), .cur_ss(cur_ss),
        .upd_en(upd_en), .alm_en(alm_en), .per_en(per_en),
        .alm_hh(alm_hh), .alm_mm(alm_mm), .alm_ss(alm_ss),
        .per_rate_log2(per_rate_log2),
        .irq_strobe(irq_strobe), .irq_word(irq_word),
        .cmp_next(cmp_next), .lost_ticks(lost_ticks)
    );

    always @(negedge clk) begin
        if (!rst && irq_strobe) begin
            n_stb++;
            last_word = irq_word;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // apply a counter value, wait for processing, return strobes seen
    task automatic tick(input logic [31:0] c, output int strobes);
        int s0;
        s0 = n_stb;
        @(negedge clk) cnt_now = c;
        repeat (14) @(negedge clk);
        strobes = n_stb - s0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int s;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 strobe", {31'd0, irq_strobe}, 32'd0);
        chk("R1 word", {16'd0, irq_word}, 32'd0);
        chk("R1 cmp", cmp_next, 32'd0);
        chk("R1 lost", {24'd0, lost_ticks}, 32'd0);

        // R11: disabled, counter past comparator: nothing happens
        tick(32'd1000, s);
        chk("R11 no strobe while off", s, 0);
        chk("R11 cmp held while off", cmp_next, 32'd0);

        // R2: arm on update enable
        @(negedge clk) upd_en = 1'b1;
        repeat (3) @(negedge clk);
        ecmp = 32'd1000 + BASE_D;
        chk("R2 arm", cmp_next, ecmp);

        // R5: first seconds value only recorded
        cur_ss = 6'd5;
        tick(ecmp, s); ecmp += BASE_D;
        chk("R5 first record no flag", s, 0);
        chk("R3 single step", cmp_next, ecmp);
        chk("R4 no loss", {24'd0, lost_ticks}, 32'd0);
        tick(ecmp, s); ecmp += BASE_D;
        chk("R5 same second no flag", s, 0);
        cur_ss = 6'd6;
        tick(ecmp, s); ecmp += BASE_D;
        chk("R5 changed second flags", s, 1);
        chk("R10 update word", {16'd0, last_word}, 32'h190);

        // R3/R4: catch-up over three missed ticks
        tick(ecmp + 3*BASE_D, s); ecmp += 4*BASE_D;
        chk("R3 catch-up cmp", cmp_next, ecmp);
        chk("R4 lost count", {24'd0, lost_ticks}, 32'd3);
        chk("R10 no flag no strobe", s, 0);

        // R11: disable all, counter far past
        @(negedge clk) upd_en = 1'b0;
        tick(ecmp + 32'd5000, s);
        chk("R11 strobe off", s, 0);
        chk("R11 cmp held", cmp_next, ecmp);

        // R3 wrap: arm near top of range
        tick(32'hFFFF_FE00, s);
        @(negedge clk) upd_en = 1'b1;
        repeat (3) @(negedge clk);
        ecmp = 32'hFFFF_FE00 + BASE_D;
        chk("R2 arm at wrap", cmp_next, 32'h0000_0200);
        tick(32'hFFFF_FF00, s);
        chk("R3 wrap not passed", cmp_next, ecmp);
        tick(ecmp, s); ecmp += BASE_D;
        chk("R3 wrap tick", cmp_next, 32'h0000_0600);
        chk("R5 re-enable invalidates", s, 0);
        cur_ss = 6'd7;
        tick(ecmp, s); ecmp += BASE_D;
        chk("R5 valid after re-enable", s, 1);

        // R6: alarm
        alm_hh = 5'd12; alm_mm = 6'd34; alm_ss = 6'd56;
        cur_hh = 5'd12; cur_mm = 6'd34; cur_ss = 6'd56;
        @(negedge clk) begin upd_en = 1'b0; alm_en = 1'b1; end
        repeat (3) @(negedge clk);
        ecmp = cnt_now + BASE_D;
        chk("R2 arm alarm", cmp_next, ecmp);
        tick(ecmp, s); ecmp += BASE_D;
        chk("R6 match", s, 1);
        chk("R10 alarm word", {16'd0, last_word}, 32'h1A0);
        cur_ss = 6'd57;
        tick(ecmp, s); ecmp += BASE_D;
        chk("R6 second mismatch", s, 0);
        cur_ss = 6'd56; cur_hh = 5'd13;
        tick(ecmp, s); ecmp += BASE_D;
        chk("R6 hour mismatch", s, 0);
        cur_hh = 5'd12; cur_mm = 6'd35;
        tick(ecmp, s); ecmp += BASE_D;
        chk("R6 minute mismatch", s, 0);
        cur_mm = 6'd34;
        tick(ecmp, s); ecmp += BASE_D;
        chk("R6 match again", s, 1);

        // R7: sweep every slow periodic rate
        @(negedge clk) begin alm_en = 1'b0; per_en = 1'b1; per_rate_log2 = 4'd6; end
        repeat (3) @(negedge clk);
        ecmp = cnt_now + BASE_D;
        chk("R2 arm periodic", cmp_next, ecmp);
        for (int k = 6; k >= 1; k--) begin
            int lim;
            per_rate_log2 = 4'(k);
            lim = 1 << (6 - k);
            for (int i = 1; i <= 2*lim; i++) begin
                tick(ecmp, s); ecmp += BASE_D;
                chk($sformatf("R7 k=%0d tick %0d", k, i), s, (i % lim == 0) ? 1 : 0);
                if (i % lim == 0)
                    chk("R10 periodic word", {16'd0, last_word}, 32'h1C0);
            end
            chk("R7 cmp step", cmp_next, ecmp);
        end

        // R8: lost ticks feed the divider (k=4, limit 4, count 0)
        per_rate_log2 = 4'd4;
        tick(ecmp + 2*BASE_D, s); ecmp += 3*BASE_D;
        chk("R8 sum 3 no flag", s, 0);
        chk("R4 lost 2", {24'd0, lost_ticks}, 32'd2);
        tick(ecmp, s); ecmp += BASE_D;
        chk("R8 sum 4 flags", s, 1);
        tick(ecmp + 4*BASE_D, s); ecmp += 5*BASE_D;
        chk("R8 lost 4 flags", s, 1);
        tick(ecmp, s); ecmp += BASE_D;
        chk("R7 divider reset after flag", s, 0);

        // R9: fast rates
        per_rate_log2 = 4'd8;
        tick(ecmp, s); ecmp += 32'(FREQ >> 8);
        chk("R9 256Hz step", cmp_next, ecmp);
        chk("R9 256Hz flag", s, 1);
        tick(ecmp, s); ecmp += 32'(FREQ >> 8);
        chk("R9 256Hz flag again", s, 1);
        per_rate_log2 = 4'd13;
        tick(ecmp, s); ecmp += 32'(FREQ >> 13);
        chk("R9 8192Hz step", cmp_next, ecmp);
        chk("R9 8192Hz flag", s, 1);
        tick(ecmp + 2*32'(FREQ >> 13), s); ecmp += 3*32'(FREQ >> 13);
        chk("R9 fast catch-up", cmp_next, ecmp);
        chk("R4 fast lost", {24'd0, lost_ticks}, 32'd2);

        // R11: final disable
        @(negedge clk) per_en = 1'b0;
        tick(ecmp + 32'd100000, s);
        chk("R11 final no strobe", s, 0);
        chk("R11 final cmp held", cmp_next, ecmp);

        finish_run();
    end

endmodule